// File: doc/BRIEF.md
# Backscatter Subcarrier Clock Synthesizer

This block produces the square-wave subcarrier that a passive tag uses to backscatter its reply. The receive path supplies the length of the backscatter calibration symbol as a count of whole clock cycles. A one-bit selector chooses the divide ratio, either 8 or 64/3. On a start pulse the block divides the calibration count by the divide ratio with rounding, using a shift-and-subtract divider. It then runs a free-running square wave whose high and low phases are whole numbers of clock cycles. It also gives a one-cycle strobe at the start of every period for the line encoder that follows.

Two ways of splitting the period are offered. In the equal-halves mode each half is rounded on its own, so both halves have the same length. In the exact-period mode the full period is rounded once and then split. This gives a closer frequency, but an odd period leaves the low half one clock longer than the high half. A stop pulse silences the output at once. Configuration inputs are plain levels sampled on start, so there is no streaming data path and no back-pressure.

Top module: `blf_synth`

## Requirements
- R1: After reset `blf_out`, `period_strobe` and `active` are all 0.
- R2: With `mode_sel`=0 and `dr_sel`=0 (divide ratio 8), high and low phases each last floor((N+8)/16) clocks, where N is `trcal_cycles` sampled on start.
- R3: With `mode_sel`=0 and `dr_sel`=1 (divide ratio 64/3), high and low phases each last floor((3N+64)/128) clocks.
- R4: With `mode_sel`=1 and `dr_sel`=0, the period is P=floor((N+4)/8). High lasts floor(P/2) clocks and low lasts P-floor(P/2) clocks.
- R5: With `mode_sel`=1 and `dr_sel`=1, the period is P=floor((3N+32)/64). It is split into high and low the same way as in R4.
- R6: Any phase length that computes to 0 is replaced by 1, so the output always toggles.
- R7: After start the output stays low while the divider runs. It then begins with a high phase no more than 19 clocks after the start pulse (default width). A start while running restarts the computation from low.
- R8: `period_strobe` is high for exactly one clock per period, in the first clock of each high phase.
- R9: The high/low pattern repeats with unchanged lengths until stop or the next start.
- R10: One clock after stop is sampled, `blf_out` and `active` are 0, and they stay 0 until the next start.
- R11: A stop while the divider is busy cancels it, and the output never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trcal_cycles | input | TRCAL_W | Calibration symbol length in clocks, sampled on start |
| dr_sel | input | 1 | 0: divide ratio 8, 1: divide ratio 64/3 |
| mode_sel | input | 1 | 0: equal halves, 1: exact period split |
| start | input | 1 | One-clock pulse: compute and begin |
| stop | input | 1 | One-clock pulse: force idle, output low |
| blf_out | output | 1 | Subcarrier square wave |
| period_strobe | output | 1 | High in first clock of each period |
| active | output | 1 | High while the wave is running |

## Verification
The bench sweeps calibration counts in all four mode and ratio combinations. The sweep includes counts that round to zero, counts that sit on a rounding boundary, and odd exact periods. A divider that truncates instead of rounding would produce phases one clock short. A missing clamp would hang the output on a zero count. Swapping the halves of an odd period would lengthen the high phase instead of the low one. Two full periods are measured per case, which catches reload errors. Stop is checked both during the wave and mid-division, which catches a divider that still fires its result after a cancel.

// File: rtl/blf_pkg.sv
package blf_pkg;
  localparam int DEN_W = 8;

  // divisor after scaling: ratio 8 -> 8/16, ratio 64/3 -> 64/128 (numerator scaled by 3)
  function automatic logic [DEN_W-1:0] pick_den(input logic ratio_sel, input logic exact_mode);
    logic [DEN_W-1:0] d;
    case ({ratio_sel, exact_mode})
      2'b00:   d = 8'd16;
      2'b01:   d = 8'd8;
      2'b10:   d = 8'd128;
      default: d = 8'd64;
    endcase
    return d;
  endfunction

  typedef enum logic {WAVE_IDLE = 1'b0, WAVE_RUN = 1'b1} wave_state_t;
endpackage

// File: rtl/blf_restoring_div.sv
module blf_restoring_div
  import blf_pkg::*;
#(
  parameter int NUM_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done,
  output logic             busy
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [NUM_W-1:0]  quo_q;
  logic [STEP_W-1:0] steps_q;
  logic [DEN_W:0]    trial;
  logic              fits;
  logic [DEN_W:0]    diff;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    fits  = (trial >= {1'b0, den_q});
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      steps_q <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (abort) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      steps_q <= '0;
    end else if (load) begin
      rem_q   <= '0;
      den_q   <= den;
      quo_q   <= num;
      steps_q <= STEP_W'(NUM_W);
      busy    <= 1'b1;
      done    <= 1'b0;
    end else if (busy) begin
      rem_q   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_q   <= {quo_q[NUM_W-2:0], fits};
      steps_q <= steps_q - 1'b1;
      if (steps_q == STEP_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = quo_q;

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q < den_q)) else $error("remainder out of range"); // R2
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held"); // R7
endmodule

// File: rtl/blf_count_plan.sv
module blf_count_plan
  import blf_pkg::*;
#(
  parameter int TRCAL_W = 12,
  parameter int NUM_W   = TRCAL_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TRCAL_W-1:0] trcal_cycles,
  input  logic               dr_sel,
  input  logic               mode_sel,
  input  logic               start,
  input  logic               stop,
  output logic [NUM_W-1:0]   hi_len,
  output logic [NUM_W-1:0]   lo_len,
  output logic               lens_valid
);
  logic [NUM_W-1:0] n_ext;
  logic [NUM_W-1:0] scaled;
  logic [DEN_W-1:0] den;
  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] quo;
  logic             div_done;
  logic             div_busy;
  logic             exact_q;
  logic [NUM_W-1:0] q_half;
  logic [NUM_W-1:0] q_rest;

  always_comb begin
    n_ext  = NUM_W'(trcal_cycles);
    scaled = dr_sel ? (n_ext + (n_ext << 1)) : n_ext;
    den    = pick_den(dr_sel, mode_sel);
    num    = scaled + NUM_W'(den >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                exact_q <= 1'b0;
    else if (start && !stop)   exact_q <= mode_sel;
  end

  blf_restoring_div #(.NUM_W(NUM_W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .abort (stop),
    .num   (num),
    .den   (den),
    .quo   (quo),
    .done  (div_done),
    .busy  (div_busy)
  );

  function automatic logic [NUM_W-1:0] at_least_one(input logic [NUM_W-1:0] v);
    return (v == '0) ? NUM_W'(1) : v;
  endfunction

  always_comb begin
    q_half = quo >> 1;
    q_rest = quo - q_half;
    if (exact_q) begin
      hi_len = at_least_one(q_half);
      lo_len = at_least_one(q_rest);
    end else begin
      hi_len = at_least_one(quo);
      lo_len = at_least_one(quo);
    end
  end

  assign lens_valid = div_done && !start && !stop;

  AST_EQUAL_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (lens_valid && !exact_q) |-> (hi_len == lo_len)) else $error("halves differ"); // R2
  AST_SPLIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (lens_valid && exact_q) |-> (lo_len >= hi_len) && (lo_len - hi_len <= NUM_W'(1))) else $error("bad split"); // R4
  AST_NONZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    lens_valid |-> (hi_len != '0) && (lo_len != '0)) else $error("zero length"); // R6
endmodule

// File: rtl/blf_wave_gen.sv
module blf_wave_gen
  import blf_pkg::*;
#(
  parameter int NUM_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             start,
  input  logic             stop,
  input  logic [NUM_W-1:0] hi_len,
  input  logic [NUM_W-1:0] lo_len,
  output logic             wave,
  output logic             strobe,
  output logic             running
);
  wave_state_t      state_q;
  logic [NUM_W-1:0] cnt_q;
  logic [NUM_W-1:0] hi_q;
  logic [NUM_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WAVE_IDLE;
      cnt_q   <= '0;
      hi_q    <= NUM_W'(1);
      lo_q    <= NUM_W'(1);
      wave    <= 1'b0;
      strobe  <= 1'b0;
    end else if (stop || start) begin
      state_q <= WAVE_IDLE;
      wave    <= 1'b0;
      strobe  <= 1'b0;
      cnt_q   <= '0;
    end else if (load) begin
      state_q <= WAVE_RUN;
      hi_q    <= hi_len;
      lo_q    <= lo_len;
      cnt_q   <= hi_len - 1'b1;
      wave    <= 1'b1;
      strobe  <= 1'b1;
    end else if (state_q == WAVE_RUN) begin
      if (cnt_q == '0) begin
        wave   <= ~wave;
        strobe <= ~wave;
        cnt_q  <= wave ? (lo_q - 1'b1) : (hi_q - 1'b1);
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        strobe <= 1'b0;
      end
    end else begin
      strobe <= 1'b0;
    end
  end

  assign running = (state_q == WAVE_RUN);

  AST_STROBE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> wave) else $error("strobe outside high"); // R8
  AST_RISE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave) |-> strobe) else $error("rise without strobe"); // R8
  AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!wave && !running)) else $error("stop ignored"); // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wave) else $error("idle output high"); // R10
  AST_HOLD_MIDPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && !$past(load) && ($past(cnt_q) != '0)) |-> $stable(wave))
    else $error("early toggle"); // R9
endmodule

// File: rtl/blf_synth.sv
module blf_synth
  import blf_pkg::*;
#(
  parameter int TRCAL_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TRCAL_W-1:0] trcal_cycles,
  input  logic               dr_sel,
  input  logic               mode_sel,
  input  logic               start,
  input  logic               stop,
  output logic               blf_out,
  output logic               period_strobe,
  output logic               active
);
  localparam int NUM_W = TRCAL_W + 3;

  logic [NUM_W-1:0] hi_len;
  logic [NUM_W-1:0] lo_len;
  logic             lens_valid;

  blf_count_plan #(.TRCAL_W(TRCAL_W), .NUM_W(NUM_W)) plan_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trcal_cycles (trcal_cycles),
    .dr_sel       (dr_sel),
    .mode_sel     (mode_sel),
    .start        (start),
    .stop         (stop),
    .hi_len       (hi_len),
    .lo_len       (lo_len),
    .lens_valid   (lens_valid)
  );

  blf_wave_gen #(.NUM_W(NUM_W)) wave_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (lens_valid),
    .start   (start),
    .stop    (stop),
    .hi_len  (hi_len),
    .lo_len  (lo_len),
    .wave    (blf_out),
    .strobe  (period_strobe),
    .running (active)
  );

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !blf_out) else $error("output high during compute"); // R7
endmodule

// File: tb/blf_synth_tb.sv
module blf_synth_tb_top;
  localparam int TRCAL_W = 12;
  localparam int NUM_W   = TRCAL_W + 3;
  localparam int MAX_LAT = NUM_W + 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [TRCAL_W-1:0] trcal_cycles = '0;
  logic               dr_sel = 1'b0;
  logic               mode_sel = 1'b0;
  logic               start = 1'b0;
  logic               stop = 1'b0;
  logic               blf_out;
  logic               period_strobe;
  logic               active;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int start_cyc = 0;
  int meas_done = 0;
  int exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  blf_synth #(.TRCAL_W(TRCAL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .trcal_cycles(trcal_cycles), .dr_sel(dr_sel),
    .mode_sel(mode_sel), .start(start), .stop(stop), .blf_out(blf_out),
    .period_strobe(period_strobe), .active(active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference from R2..R6
  function automatic void ref_lens(input int n, input bit dr, input bit md, output int hi, output int lo);
    int p;
    if (!md) begin
      hi = dr ? (3*n + 64) / 128 : (n + 8) / 16;
      if (hi == 0) hi = 1;
      lo = hi;
    end else begin
      p  = dr ? (3*n + 32) / 64 : (n + 4) / 8;
      hi = p / 2;
      lo = p - hi;
      if (hi == 0) hi = 1;
      if (lo == 0) lo = 1;
    end
  endfunction

  // monitor: pops expected lengths, measures two periods
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() >= 3) begin
        int eh, el, tag, lat, guard;
        eh = exp_q.pop_front(); el = exp_q.pop_front(); tag = exp_q.pop_front();
        guard = 0;
        while (!blf_out && guard < 100) begin @(negedge clk); guard++; end
        lat = cyc - start_cyc;
        check(blf_out && lat <= MAX_LAT, "R7 first rise latency", lat, MAX_LAT);
        for (int per = 0; per < 2; per++) begin
          int h, l, sc;
          bit first_ok;
          h = 0; l = 0; sc = 0;
          first_ok = period_strobe;
          while (blf_out && h < 5000) begin
            if (period_strobe) sc++;
            h++; @(negedge clk);
          end
          while (!blf_out && l < 5000) begin
            if (period_strobe) sc++;
            l++; @(negedge clk);
          end
          if (tag == 0) begin
            check(h == eh, "R2 high length", h, eh);
            check(l == el, "R2 low length", l, el);
          end else if (tag == 1) begin
            check(h == eh, "R3 high length", h, eh);
            check(l == el, "R3 low length", l, el);
          end else if (tag == 2) begin
            check(h == eh, "R4 high length", h, eh);
            check(l == el, "R4 low length", l, el);
          end else begin
            check(h == eh, "R5 high length", h, eh);
            check(l == el, "R5 low length", l, el);
          end
          if (eh == 1 || el == 1) check(h >= 1 && l >= 1, "R6 clamp toggles", h, 1);
          check(first_ok && sc == 1, "R8 one strobe at high start", sc, 1);
          if (per == 1) check(h == eh && l == el, "R9 repeat period", h + l, eh + el);
        end
        meas_done++;
      end
    end
  end

  task automatic run_case(input int n, input bit dr, input bit md);
    int eh, el, target;
    ref_lens(n, dr, md, eh, el);
    exp_q.push_back(eh); exp_q.push_back(el); exp_q.push_back({md, dr});
    target = meas_done + 1;
    trcal_cycles = TRCAL_W'(n); dr_sel = dr; mode_sel = md;
    start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    wait (meas_done == target);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(!blf_out && !active, "R10 stop silences", blf_out, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (blf_out) begin check(0, "R10 stays low", 1, 0); break; end
    end
  endtask

  initial begin
    int ns[10] = '{0, 5, 12, 20, 100, 101, 257, 1000, 2047, 4095};
    bit rose;
    repeat (2) @(negedge clk);
    check(!blf_out && !period_strobe && !active, "R1 reset outputs", {blf_out, period_strobe, active}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!blf_out && !active, "R1 idle after reset", blf_out, 0);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 10; k++)
        run_case(ns[k], m[0], m[1]);
    // R11: stop during division
    trcal_cycles = TRCAL_W'(300); dr_sel = 1'b0; mode_sel = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    rose = 0;
    for (int i = 0; i < MAX_LAT + 10; i++) begin @(negedge clk); if (blf_out || active) rose = 1; end
    check(!rose, "R11 cancel mid-division", rose, 0);
    // R7: restart while running begins from low then recovers
    trcal_cycles = TRCAL_W'(64); dr_sel = 1'b0; mode_sel = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (MAX_LAT + 6) @(negedge clk);
    trcal_cycles = TRCAL_W'(160);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(!blf_out, "R7 restart forces low", blf_out, 0);
    run_case(160, 1'b0, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule